// File: doc/BRIEF.md
# Framed Audio Codec Serial Interface

This block is a serial master that talks to audio converters. From a clock enable it makes a bit clock and a frame marker, shifts transmit words out and shifts receive words in. It supports two framings. In the framed synchronous mode a one-bit-wide sync pulse comes before each frame. In the I2S-style mode a word-select line tells the left slot group from the right one. Each frame or group carries 1 to 4 slots, and each slot is 1 to 16 bits wide.

Software fills a 4-entry transmit buffer and empties a 4-entry receive buffer. The interrupt pulses once for each group of slots, so the processor is called only after up to four words have moved. The slots of a group run back to back with no gap bits between them. A codec word wider than 16 bits can therefore be carried as several slots, and its pieces sit in consecutive buffer entries. Configuration is written while the block is disabled. After `enable` is raised the timing runs with no further attention.

Top module: `codec_serial_if`

## Requirements
- R1: While reset is applied, and until the first enabled bit step after it, `bclk`, `fsync`, `sdo`, `irq`, `tx_unf` and `rx_valid` are all 0. The reset takes effect at once and is released on a clock edge. Dropping `enable` returns `bclk`, `fsync` and `sdo` to 0.
- R2: While enabled, each cycle with `bit_en` high toggles `bclk`, so one bit lasts two enables. A group lasts exactly 1 + S*W bit clocks: one lead bit followed by S slots of W bits.
- R3: Framed mode (`cfg_fmt`=0): `fsync` is high for exactly the lead bit before the first slot, and low during every data bit.
- R4: I2S mode (`cfg_fmt`=1): `fsync` acts as word select. It is 0 for the first (left) group after enable and 1 for the following (right) group, and it changes only on the falling `bclk` edge that starts a lead bit, which is one bit clock before the MSB.
- R5: `sdo` changes only on falling `bclk` edges. It is 0 during the lead bit and sends the low W bits of each transmit entry MSB first.
- R6: `sdi` is sampled on rising `bclk` edges of data bits only. Each received slot is pushed right-justified, with the bits above W cleared.
- R7: Slots are contiguous and use buffer entries in order. With W=16 and S=2, a 32-bit codec word moves as two slots, high half first.
- R8: `irq` is a one-cycle pulse, raised together with the rising `bclk` of the last bit of the last slot. It fires once per group.
- R9: When a slot starts with the transmit buffer empty, that slot sends zeros and `tx_unf` pulses for one cycle.
- R10: A write to a transmit buffer that already holds 4 words is dropped.
- R11: The configuration fields encode W-1 in `cfg_wlen` (0..15) and S-1 in `cfg_slots` (0..3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the serial timing; low holds it idle |
| bit_en | input | 1 | Half-bit clock enable |
| cfg_fmt | input | 1 | 0 framed synchronous, 1 I2S-style |
| cfg_wlen | input | 4 | Slot width minus one |
| cfg_slots | input | 2 | Slots per group minus one |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | 16 | Transmit word, right-justified |
| rx_rd | input | 1 | Receive buffer pop strobe |
| rx_data | output | 16 | Oldest received word |
| rx_valid | output | 1 | Receive buffer not empty |
| sdi | input | 1 | Serial data from the codec |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync or word select |
| sdo | output | 1 | Serial data to the codec |
| irq | output | 1 | Group-complete pulse |
| tx_unf | output | 1 | Transmit underflow pulse |

## Verification
Two events can land on the same clock edge. The buffer can be written in the cycle after a slot has just popped its word, and the receive buffer can be read in the very cycle the last slot pushes its word while the same edge raises `irq`. The bench provokes both of these in every configuration of a sweep over both framings, every slot width and every slot count. It refills the transmit buffer right after each slot start and reads each received word straight away, which keeps every word and every pulse on its expected edge. Separate runs with an empty buffer and with an over-filled buffer are judged by the zero bits and the number of `tx_unf` pulses.

// File: rtl/codec_if_pkg.sv
package codec_if_pkg;

  localparam int SLOT_W_DEF = 16;
  localparam int DEPTH_DEF  = 4;

  typedef enum logic {
    FMT_FRAMED = 1'b0,
    FMT_I2S    = 1'b1
  } fmt_e;

  // One-cycle strobes produced by the bit sequencer
  typedef struct packed {
    logic load;      // falling edge entering the first bit of a slot
    logic shift;     // falling edge entering a later bit of a slot
    logic lead;      // falling edge entering the lead bit of a group
    logic samp;      // rising edge inside a data bit
    logic slot_end;  // rising edge of the last bit of a slot
    logic grp_end;   // rising edge of the last bit of the last slot
  } seq_ev_t;

endpackage

// File: rtl/codec_fifo.sv
module codec_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem_q[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (do_push) wr_n = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_n = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din;
  end

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/codec_bit_seq.sv
module codec_bit_seq
  import codec_if_pkg::*;
#(
  parameter int SLOT_W    = 16,
  parameter int MAX_SLOTS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic                          bit_en,
  input  fmt_e                          fmt,
  input  logic [$clog2(SLOT_W+1)-1:0]   last_bit,
  input  logic [$clog2(MAX_SLOTS)-1:0]  last_slot_idx,
  output logic                          bclk,
  output logic                          fs,
  output seq_ev_t                       ev
);
  localparam int BW = $clog2(SLOT_W + 1);
  localparam int SW = $clog2(MAX_SLOTS);

  logic          bclk_q, bclk_n, ws_q, ws_n, fs_q, fs_n;
  logic [BW-1:0] bit_q, bit_n;
  logic [SW-1:0] slot_q, slot_n;
  logic          at_last, last_slot;

  assign at_last   = (bit_q == last_bit);
  assign last_slot = (slot_q == last_slot_idx);

  always_comb begin
    bclk_n = bclk_q;
    bit_n  = bit_q;
    slot_n = slot_q;
    ws_n   = ws_q;
    ev     = '0;
    if (!enable) begin
      bclk_n = 1'b0;
      bit_n  = '0;
      slot_n = '0;
      ws_n   = 1'b0;
    end else if (bit_en) begin
      bclk_n = !bclk_q;
      if (!bclk_q) begin
        ev.samp     = (bit_q != '0);
        ev.slot_end = ev.samp && at_last;
        ev.grp_end  = ev.slot_end && last_slot;
      end else if (bit_q == '0) begin
        bit_n   = BW'(1);
        ev.load = 1'b1;
      end else if (!at_last) begin
        bit_n    = bit_q + BW'(1);
        ev.shift = 1'b1;
      end else if (!last_slot) begin
        bit_n   = BW'(1);
        slot_n  = slot_q + SW'(1);
        ev.load = 1'b1;
      end else begin
        bit_n   = '0;
        slot_n  = '0;
        ws_n    = !ws_q;
        ev.lead = 1'b1;
      end
    end
    fs_n = (fmt == FMT_I2S) ? ws_n : (enable && (bit_n == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      bit_q  <= '0;
      slot_q <= '0;
      ws_q   <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      bclk_q <= bclk_n;
      bit_q  <= bit_n;
      slot_q <= slot_n;
      ws_q   <= ws_n;
      fs_q   <= fs_n;
    end
  end

  assign bclk = bclk_q;
  assign fs   = fs_q;

  // R2
  bclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bit_en) |=> (bclk_q != $past(bclk_q)));

  // R3
  sync_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_FRAMED && ev.samp) |-> !fs_q);

  // R4
  ws_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_I2S && enable && !$stable(fs_q)) |-> $fell(bclk_q));

endmodule

// File: rtl/codec_serial_if.sv
module codec_serial_if
  import codec_if_pkg::*;
#(
  parameter int SLOT_W = SLOT_W_DEF,
  parameter int DEPTH  = DEPTH_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      bit_en,
  input  logic                      cfg_fmt,
  input  logic [$clog2(SLOT_W)-1:0] cfg_wlen,
  input  logic [$clog2(DEPTH)-1:0]  cfg_slots,
  input  logic                      tx_wr,
  input  logic [SLOT_W-1:0]         tx_data,
  input  logic                      rx_rd,
  output logic [SLOT_W-1:0]         rx_data,
  output logic                      rx_valid,
  input  logic                      sdi,
  output logic                      bclk,
  output logic                      fsync,
  output logic                      sdo,
  output logic                      irq,
  output logic                      tx_unf
);
  localparam int BW = $clog2(SLOT_W + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  seq_ev_t            ev;
  logic [BW-1:0]      last_bit;
  logic [SLOT_W-1:0]  wmask, tx_head, rx_word;
  logic               tx_empty, tx_full, rx_empty, rx_full;
  logic [SLOT_W-1:0]  tx_sh_q, tx_sh_n, rx_sh_q, rx_sh_n;
  logic               irq_q, irq_n, unf_q, unf_n;

  assign last_bit = BW'(cfg_wlen) + BW'(1);
  assign wmask    = ~({SLOT_W{1'b1}} << last_bit);
  assign rx_word  = {rx_sh_q[SLOT_W-2:0], sdi} & wmask;

  codec_bit_seq #(.SLOT_W(SLOT_W), .MAX_SLOTS(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_s), .enable(enable), .bit_en(bit_en),
    .fmt(fmt_e'(cfg_fmt)), .last_bit(last_bit), .last_slot_idx(cfg_slots),
    .bclk(bclk), .fs(fsync), .ev(ev)
  );

  codec_fifo #(.W(SLOT_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_s), .push(tx_wr), .din(tx_data),
    .pop(ev.load), .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  codec_fifo #(.W(SLOT_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_s), .push(ev.slot_end), .din(rx_word),
    .pop(rx_rd), .dout(rx_data), .empty(rx_empty), .full(rx_full)
  );

  assign rx_valid = !rx_empty;

  always_comb begin
    tx_sh_n = tx_sh_q;
    rx_sh_n = rx_sh_q;
    if (!enable)       tx_sh_n = '0;
    else if (ev.load)  tx_sh_n = tx_empty ? '0 : tx_head;
    else if (ev.shift) tx_sh_n = tx_sh_q << 1;
    else if (ev.lead)  tx_sh_n = '0;
    if (ev.samp) rx_sh_n = {rx_sh_q[SLOT_W-2:0], sdi};
    irq_n = ev.grp_end;
    unf_n = ev.load && tx_empty;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      irq_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      tx_sh_q <= tx_sh_n;
      rx_sh_q <= rx_sh_n;
      irq_q   <= irq_n;
      unf_q   <= unf_n;
    end
  end

  assign sdo    = tx_sh_q[cfg_wlen];
  assign irq    = irq_q;
  assign tx_unf = unf_q;

  // R5
  sdo_fall_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(sdo) |-> ($fell(bclk) || !$past(enable)));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_s)
    irq |-> $rose(bclk));

  // R9
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    tx_unf |-> (!sdo && $fell(bclk)));

endmodule

// File: tb/codec_serial_if_test.sv
`timescale 1ns/1ps
module codec_serial_if_test;

  logic        clk = 1'b0;
  logic        rst_n, enable, bit_en, cfg_fmt, tx_wr, rx_rd, sdi;
  logic [3:0]  cfg_wlen;
  logic [1:0]  cfg_slots;
  logic [15:0] tx_data, rx_data;
  logic        rx_valid, bclk, fsync, sdo, irq, tx_unf;
  int          nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  codec_serial_if uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bit_en(bit_en),
    .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_slots(cfg_slots),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_valid(rx_valid), .sdi(sdi), .bclk(bclk), .fsync(fsync),
    .sdo(sdo), .irq(irq), .tx_unf(tx_unf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] txpat(input int i, input int s);
    return 16'(32'hA5C3 ^ (i * 32'h1357) ^ (s * 32'h0B1D));
  endfunction

  function automatic logic [15:0] rxpat(input int i, input int s);
    return 16'(32'h3C96 + i * 32'h0F1B + s * 32'h0457);
  endfunction

  // Runs two groups with slot width wl+1 and ns slots (R11 encodings)
  task automatic run_cfg(input bit fmt, input int wl, input int ns,
                         input int pre, input bit refill);
    int W = wl + 1;
    int tot = 2 * ns;
    int seed = wl * 8 + ns * 2 + int'(fmt);
    int avail, nw, bpos, slot, grp, pend, rk, irqs, unfs, rises, div, tick, g;
    logic [15:0] mask, w;
    bit pb;
    string dreq;
    avail = refill ? tot : ((pre < 4) ? pre : 4);
    mask  = (W == 16) ? 16'hFFFF : 16'((32'd1 << W) - 1);
    dreq  = (W == 16 && ns >= 2) ? "R7" : "R5";
    div   = 2 + (wl % 2);
    nw = pre; bpos = 0; slot = 0; grp = 0; pend = 0; rk = 0;
    irqs = 0; unfs = 0; rises = 0; tick = 0; pb = 1'b0;
    @(negedge clk);
    enable = 1'b0; bit_en = 1'b0;
    cfg_fmt = fmt; cfg_wlen = 4'(wl); cfg_slots = 2'(ns - 1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < pre; i++) begin
      tx_wr = 1'b1; tx_data = txpat(i, seed);
      @(negedge clk);
    end
    tx_wr = 1'b0;
    enable = 1'b1;
    while (grp < 2 || pend > 0) begin
      @(negedge clk);
      tx_wr = 1'b0; rx_rd = 1'b0;
      if (irq) irqs++;
      if (tx_unf) unfs++;
      if (!pb && bclk) begin
        rises++;
        g = grp * ns + slot;
        w = (g < avail) ? txpat(g, seed) : 16'h0;
        if (bpos == 0) chk(sdo == 1'b0, "R5", int'(sdo), 0);
        else chk(sdo == w[W - bpos], dreq, int'(sdo), int'(w[W - bpos]));
        if (fmt) chk(fsync == grp[0], "R4", int'(fsync), grp % 2);
        else chk(fsync == (bpos == 0), "R3", int'(fsync), int'(bpos == 0));
        chk(irq == (bpos == W && slot == ns - 1), "R8", int'(irq),
            int'(bpos == W && slot == ns - 1));
        if (bpos == W) pend++;
      end else begin
        chk(irq == 1'b0, "R8", int'(irq), 0);
      end
      if (pb && !bclk) begin
        if (bpos == 0) bpos = 1;
        else if (bpos < W) bpos++;
        else if (slot < ns - 1) begin slot++; bpos = 1; end
        else begin bpos = 0; slot = 0; grp++; end
        if (bpos >= 1) begin
          w = rxpat(grp * ns + slot, seed);
          sdi = w[W - bpos];
        end else sdi = ~sdi;
        if (bpos == 1 && refill && nw < tot) begin
          tx_wr = 1'b1; tx_data = txpat(nw, seed); nw++;
        end
      end
      if (pend > 0) begin
        w = rxpat(rk, seed) & mask;
        chk(rx_valid && rx_data == w, "R6", int'(rx_data), int'(w));
        rx_rd = 1'b1; pend--; rk++;
      end
      pb = bclk;
      bit_en = (tick % div == 0);
      tick++;
    end
    @(negedge clk);
    rx_rd = 1'b0; enable = 1'b0; bit_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(irqs == 2, "R8", irqs, 2);
    chk(unfs == tot - avail, (pre > 4) ? "R10" : "R9", unfs, tot - avail);
    chk(rises == 2 * (1 + ns * W), "R2", rises, 2 * (1 + ns * W));
    chk(rk == tot, "R11", rk, tot);
    chk(!bclk && !sdo && !fsync && !rx_valid, "R1", int'({bclk, sdo, fsync, rx_valid}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; bit_en = 1'b0; cfg_fmt = 1'b0;
    cfg_wlen = 4'd0; cfg_slots = 2'd0; tx_wr = 1'b0; tx_data = '0;
    rx_rd = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state, then still idle after release with enable low
    chk({bclk, fsync, sdo, irq, tx_unf, rx_valid} == 6'b0, "R1",
        int'({bclk, fsync, sdo, irq, tx_unf, rx_valid}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({bclk, fsync, sdo, irq, tx_unf, rx_valid} == 6'b0, "R1",
        int'({bclk, fsync, sdo, irq, tx_unf, rx_valid}), 0);
    // sweep: both framings, every slot count, every width, buffer kept fed
    for (int f = 0; f < 2; f++)
      for (int s = 1; s <= 4; s++)
        for (int wl = 0; wl < 16; wl++)
          run_cfg(f[0], wl, s, (2 * s < 4) ? 2 * s : 4, 1'b1);
    // R9: empty buffer, every slot underflows
    run_cfg(1'b0, 5, 2, 0, 1'b0);
    // R10: six writes into four entries, two are dropped
    run_cfg(1'b1, 7, 4, 6, 1'b0);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule